// File: doc/BRIEF.md
# Multi-Device Bulk Erase Sequencer

This controller sits on the host side of a byte-wide bus shared by several flash devices. Each device has its own active-low chip enable. On a start pulse the controller puts every device in read mode and reads every byte of every device. If any byte is not zero, it hands the array to an external programming engine through a request/acknowledge pair. When the preprogram condition holds, it runs erase pulses. Each pulse is two erase command writes followed by a long settle wait, and it goes only to devices that have not yet verified clean.

After each pulse, the devices are verified one at a time in ascending index order. Each device keeps its own verify cursor. A byte is verified by writing the erase-verify command with the byte's address, waiting a short settle time, reading the byte, and expecting all ones. A mismatch leaves that device's cursor where it is, so the next round resumes at the failing byte. A device whose cursor runs past the last address is marked passed and is never enabled for an erase command again.

The run ends when every device has passed or when the shared pulse budget is used up. It then writes the read command to all devices and raises a done level. The per-device pass and fail flags are held until the next start.

Top module: `multi_flash_eraser`

## Requirements
- R1: Out of reset all chip enables are high, both strobes, `done` and `pp_req` are low, and all pass and fail flags are low.
- R2: After `start`, the block writes 00h to all devices and then reads every byte of every device. If any byte is not 00h, it raises `pp_req` and holds it until `pp_ack`. No 20h write happens while any byte is still non-zero.
- R3: An erase pulse is two consecutive writes of 20h. The pulses are numbered from 1 and there are never more than MAX_PULSES of them, so a device that has not passed receives exactly 2·min(need, MAX_PULSES) such writes.
- R4: The first erase-verify command after a pulse comes no sooner than ERASE_WAIT+2 cycles after the second 20h write of that pulse.
- R5: Erase verify writes A0h to one device at its cursor address. The read strobe to the same device and address follows exactly VERIFY_WAIT+1 cycles later. The byte counts as erased only if `bus_rdata` equals FFh in the cycle after the read strobe.
- R6: On a mismatch the device's cursor stays at the failing byte and verification moves on to the next device. The following round resumes at that byte. On a match the cursor advances.
- R7: Within one round, devices are verified in ascending index. A device whose last byte has verified is flagged passed and never sees its chip enable low during a 20h write afterwards.
- R8: If devices remain unpassed after pulse MAX_PULSES, the run stops and exactly those devices carry their fail flag. Passed devices carry the pass flag.
- R9: Before `done` rises, the last bus write is 00h with every chip enable low.
- R10: While `done` is high and `start` is low, the pass and fail flags do not change. A new `start` clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| pp_ack | input | 1 | Preprogram engine finished |
| bus_rdata | input | 8 | Read data from the selected device, valid the cycle after `bus_re` |
| ce_n | output | N_DEV | Per-device active-low chip enables |
| bus_addr | output | ADDR_W | Shared byte address |
| bus_wdata | output | 8 | Shared write data / command byte |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| pp_req | output | 1 | Request for the preprogram engine |
| done | output | 1 | Run finished, flags valid |
| dev_pass | output | N_DEV | Device verified fully erased |
| dev_fail | output | N_DEV | Device still unerased at pulse limit |

## Verification
The hardest situation to reach is a single round in which some devices are already masked, one device fails partway through its address range, and another keeps passing bytes. Only that mix shows both cursor resumption and masking at once.

The bench drives this with behavioural device models. Each byte carries its own number of pulses needed, computed arithmetically from the device index, the address and a sweep seed, so verification stalls at different addresses in different rounds. Some sweep points push one or all devices beyond the pulse budget, and others start with dirty contents to force the preprogram handshake. From the same numbers the bench predicts each device's erase-write count, verify-command count and final pass/fail.

// File: rtl/mfe_pkg.sv
package mfe_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RDCMD,
    ST_PCHK_RD,
    ST_PCHK_CMP,
    ST_PP_WAIT,
    ST_ERS_SETUP,
    ST_ERS_GO,
    ST_ERS_WAIT,
    ST_VFY_SEL,
    ST_VFY_CMD,
    ST_VFY_WAIT,
    ST_VFY_RD,
    ST_VFY_CMP,
    ST_ROUND_END,
    ST_FIN,
    ST_DONE
  } seq_state_e;

  localparam logic [7:0] OP_READ   = 8'h00;
  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_EVFY   = 8'hA0;
  localparam logic [7:0] VAL_CLEAN = 8'hFF;
  localparam logic [7:0] VAL_ZERO  = 8'h00;

endpackage

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_en = load | ~expired;
    cnt_d  = load ? load_val : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/pulse_tally.sv
module pulse_tally #(
  parameter int MAX_PULSES = 1000,
  localparam int PC_W = $clog2(MAX_PULSES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            inc,
  output logic [PC_W-1:0] count,
  output logic            at_limit
);

  logic [PC_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign at_limit = (cnt_q >= PC_W'(MAX_PULSES));
  assign count    = cnt_q;

  always_comb begin
    cnt_en = clear | (inc & ~at_limit);
    cnt_d  = clear ? PC_W'(1) : cnt_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= PC_W'(1);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3
  pulse_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= PC_W'(1)) && (cnt_q <= PC_W'(MAX_PULSES)));

  // R8
  no_inc_past_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/addr_tracker.sv
module addr_tracker #(
  parameter int N_DEV  = 4,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              adv,
  input  logic              mark,
  input  logic [N_DEV-1:0]  sel_oh,
  output logic [N_DEV-1:0]  passed,
  output logic [ADDR_W-1:0] sel_addr,
  output logic              sel_last
);

  logic [ADDR_W-1:0] cur_q [N_DEV];

  for (genvar i = 0; i < N_DEV; i++) begin : g_dev
    logic [ADDR_W-1:0] cur_d;
    logic              cur_en, pass_d, pass_en;

    always_comb begin
      cur_en  = clear | (adv & sel_oh[i]);
      cur_d   = clear ? '0 : cur_q[i] + ADDR_W'(1);
      pass_en = clear | (mark & sel_oh[i]);
      pass_d  = ~clear;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cur_q[i] <= '0;
      else if (cur_en) cur_q[i] <= cur_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       passed[i] <= 1'b0;
      else if (pass_en) passed[i] <= pass_d;
    end

    // R6
    cursor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !(adv && sel_oh[i])) |=> $stable(cur_q[i]));
  end

  always_comb begin
    sel_addr = '0;
    for (int i = 0; i < N_DEV; i++)
      if (sel_oh[i]) sel_addr = sel_addr | cur_q[i];
    sel_last = (sel_addr == '1);
  end

  // R6
  single_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv || mark) |-> $onehot(sel_oh));

endmodule

// File: rtl/multi_flash_eraser.sv
module multi_flash_eraser
  import mfe_pkg::*;
#(
  parameter int N_DEV       = 4,
  parameter int ADDR_W      = 17,
  parameter int MAX_PULSES  = 1000,
  parameter int ERASE_WAIT  = 1250000,
  parameter int VERIFY_WAIT = 750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pp_ack,
  input  logic [7:0]        bus_rdata,
  output logic [N_DEV-1:0]  ce_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  output logic              pp_req,
  output logic              done,
  output logic [N_DEV-1:0]  dev_pass,
  output logic [N_DEV-1:0]  dev_fail
);

  localparam int DEV_W  = $clog2(N_DEV + 1);
  localparam int WMAX   = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT;
  localparam int TMR_W  = $clog2(WMAX + 1);
  localparam int PC_W   = $clog2(MAX_PULSES + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  seq_state_e          state_q, state_d;
  logic [DEV_W-1:0]    dev_q, dev_d;
  logic [ADDR_W-1:0]   paddr_q, paddr_d;
  logic [N_DEV-1:0]    fail_q, fail_d;
  logic                fail_en;
  logic [N_DEV-1:0]    dev_oh;

  logic                tmr_load, tmr_exp;
  logic [TMR_W-1:0]    tmr_val;
  logic                pc_clear, pc_inc, pc_limit;
  logic [PC_W-1:0]     pc_count;
  logic                trk_clear, trk_adv, trk_mark, trk_last;
  logic [N_DEV-1:0]    passed;
  logic [ADDR_W-1:0]   trk_addr;

  always_comb begin
    for (int i = 0; i < N_DEV; i++) dev_oh[i] = (dev_q == DEV_W'(i));
  end

  wait_timer #(.CNT_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  pulse_tally #(.MAX_PULSES(MAX_PULSES)) u_pulses (
    .clk(clk), .rst_n(rst_i_n), .clear(pc_clear), .inc(pc_inc),
    .count(pc_count), .at_limit(pc_limit)
  );

  addr_tracker #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) u_track (
    .clk(clk), .rst_n(rst_i_n), .clear(trk_clear), .adv(trk_adv), .mark(trk_mark),
    .sel_oh(dev_oh), .passed(passed), .sel_addr(trk_addr), .sel_last(trk_last)
  );

  always_comb begin
    state_d   = state_q;
    dev_d     = dev_q;
    paddr_d   = paddr_q;
    fail_d    = fail_q;
    fail_en   = 1'b0;
    ce_n      = '1;
    bus_addr  = '0;
    bus_wdata = VAL_ZERO;
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    pp_req    = 1'b0;
    done      = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    pc_clear  = 1'b0;
    pc_inc    = 1'b0;
    trk_clear = 1'b0;
    trk_adv   = 1'b0;
    trk_mark  = 1'b0;

    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        done = (state_q == ST_DONE);
        if (start) begin
          trk_clear = 1'b1;
          pc_clear  = 1'b1;
          fail_d    = '0;
          fail_en   = 1'b1;
          state_d   = ST_RDCMD;
        end
      end
      ST_RDCMD: begin
        bus_we    = 1'b1;
        bus_wdata = OP_READ;
        ce_n      = '0;
        dev_d     = '0;
        paddr_d   = '0;
        state_d   = ST_PCHK_RD;
      end
      ST_PCHK_RD: begin
        bus_re   = 1'b1;
        ce_n     = ~dev_oh;
        bus_addr = paddr_q;
        state_d  = ST_PCHK_CMP;
      end
      ST_PCHK_CMP: begin
        if (bus_rdata != VAL_ZERO) begin
          state_d = ST_PP_WAIT;
        end else if (paddr_q == '1) begin
          paddr_d = '0;
          if (dev_q == DEV_W'(N_DEV - 1)) state_d = ST_ERS_SETUP;
          else begin
            dev_d   = dev_q + DEV_W'(1);
            state_d = ST_PCHK_RD;
          end
        end else begin
          paddr_d = paddr_q + ADDR_W'(1);
          state_d = ST_PCHK_RD;
        end
      end
      ST_PP_WAIT: begin
        pp_req = 1'b1;
        if (pp_ack) state_d = ST_ERS_SETUP;
      end
      ST_ERS_SETUP: begin
        bus_we    = 1'b1;
        bus_wdata = OP_ERASE;
        ce_n      = passed;
        state_d   = ST_ERS_GO;
      end
      ST_ERS_GO: begin
        bus_we    = 1'b1;
        bus_wdata = OP_ERASE;
        ce_n      = passed;
        tmr_load  = 1'b1;
        tmr_val   = TMR_W'(ERASE_WAIT - 1);
        dev_d     = '0;
        state_d   = ST_ERS_WAIT;
      end
      ST_ERS_WAIT: begin
        if (tmr_exp) state_d = ST_VFY_SEL;
      end
      ST_VFY_SEL: begin
        if (dev_q == DEV_W'(N_DEV))   state_d = ST_ROUND_END;
        else if ((passed & dev_oh) != '0) dev_d = dev_q + DEV_W'(1);
        else                          state_d = ST_VFY_CMD;
      end
      ST_VFY_CMD: begin
        bus_we    = 1'b1;
        bus_wdata = OP_EVFY;
        bus_addr  = trk_addr;
        ce_n      = ~dev_oh;
        tmr_load  = 1'b1;
        tmr_val   = TMR_W'(VERIFY_WAIT - 1);
        state_d   = ST_VFY_WAIT;
      end
      ST_VFY_WAIT: begin
        if (tmr_exp) state_d = ST_VFY_RD;
      end
      ST_VFY_RD: begin
        bus_re   = 1'b1;
        bus_addr = trk_addr;
        ce_n     = ~dev_oh;
        state_d  = ST_VFY_CMP;
      end
      ST_VFY_CMP: begin
        if (bus_rdata == VAL_CLEAN) begin
          if (trk_last) begin
            trk_mark = 1'b1;
            dev_d    = dev_q + DEV_W'(1);
            state_d  = ST_VFY_SEL;
          end else begin
            trk_adv = 1'b1;
            state_d = ST_VFY_CMD;
          end
        end else begin
          dev_d   = dev_q + DEV_W'(1);
          state_d = ST_VFY_SEL;
        end
      end
      ST_ROUND_END: begin
        if ((&passed) || pc_limit) state_d = ST_FIN;
        else begin
          pc_inc  = 1'b1;
          state_d = ST_ERS_SETUP;
        end
      end
      ST_FIN: begin
        bus_we    = 1'b1;
        bus_wdata = OP_READ;
        ce_n      = '0;
        fail_d    = ~passed;
        fail_en   = 1'b1;
        state_d   = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      dev_q   <= '0;
      paddr_q <= '0;
    end else begin
      state_q <= state_d;
      dev_q   <= dev_d;
      paddr_q <= paddr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     fail_q <= '0;
    else if (fail_en) fail_q <= fail_d;
  end

  assign dev_pass = passed;
  assign dev_fail = fail_q;

  // R5
  single_reader_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_re |-> ($onehot(~ce_n) && !bus_we));

  // R7
  masked_no_erase_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_we && bus_wdata == OP_ERASE) |-> ((~ce_n & dev_pass) == '0));

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && !start) |=> ($stable(dev_pass) && $stable(dev_fail)));

  // R2
  pp_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pp_req && !pp_ack) |=> pp_req);

  // R8
  fail_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> ((dev_pass & dev_fail) == '0) && ((dev_pass | dev_fail) == '1));

  // R3
  pulse_budget_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_ERS_SETUP) |-> (pc_count <= PC_W'(MAX_PULSES)));

endmodule

// File: tb/test_multi_flash_eraser.sv
module test_multi_flash_eraser;

  localparam int N  = 3;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int MAXP = 6;
  localparam int EW = 12;
  localparam int VW = 3;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n, start, pp_ack;
  logic [7:0] bus_rdata;
  logic [N-1:0] ce_n, dev_pass, dev_fail;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic bus_we, bus_re, pp_req, done;

  always #4 clk = ~clk;

  multi_flash_eraser #(.N_DEV(N), .ADDR_W(AW), .MAX_PULSES(MAXP),
                       .ERASE_WAIT(EW), .VERIFY_WAIT(VW)) i_multi_flash_eraser (
    .clk(clk), .rst_n(rst_n), .start(start), .pp_ack(pp_ack), .bus_rdata(bus_rdata),
    .ce_n(ce_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_re(bus_re), .pp_req(pp_req), .done(done), .dev_pass(dev_pass), .dev_fail(dev_fail)
  );

  int vectors = 0, miscompares = 0, cyc = 0;

  // device models
  logic [7:0] mem [N][DEPTH];
  int need [N][DEPTH];
  int rcv [N], ers_w [N], vfy_w [N], vad [N];
  int mode [N];             // 0 read, 1 erase armed, 2 erase done, 3 verify
  int go_cyc, a0_cyc, last_vdev;
  int bad_gap, bad_rd, bad_order, bad_mask, bad_pp, pp_seen;
  logic [7:0] last_wd;
  logic [N-1:0] last_ce;

  function automatic bit dirty();
    for (int d = 0; d < N; d++)
      for (int a = 0; a < DEPTH; a++)
        if (mem[d][a] != 8'h00) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pp_req) pp_seen = 1;
    if (bus_we) begin
      if (bus_wdata == 8'h20) begin
        if (dirty()) bad_pp++;
        for (int d = 0; d < N; d++) if (!ce_n[d] && dev_pass[d]) bad_mask++;
      end
      for (int d = 0; d < N; d++) begin
        if (!ce_n[d]) begin
          case (bus_wdata)
            8'h00: mode[d] = 0;
            8'h20: begin
              ers_w[d]++;
              if (mode[d] == 1) begin
                rcv[d]++; mode[d] = 2; go_cyc = cyc; last_vdev = -1;
              end else mode[d] = 1;
            end
            8'hA0: begin
              mode[d] = 3; vad[d] = int'(bus_addr); vfy_w[d]++;
              if (cyc - go_cyc < EW + 2) bad_gap++;
              if (d < last_vdev) bad_order++;
              last_vdev = d; a0_cyc = cyc;
            end
            default: ;
          endcase
        end
      end
      last_wd = bus_wdata; last_ce = ce_n;
    end
    if (bus_re) begin
      for (int d = 0; d < N; d++) begin
        if (!ce_n[d]) begin
          if (mode[d] == 3) begin
            if (cyc - a0_cyc != VW + 1 || int'(bus_addr) != vad[d]) bad_rd++;
            bus_rdata <= (rcv[d] >= need[d][bus_addr]) ? 8'hFF : 8'h00;
          end else bus_rdata <= mem[d][bus_addr];
        end
      end
    end
  end

  // preprogram engine model
  initial begin
    pp_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (pp_req) begin
        repeat (5) @(negedge clk);
        for (int d = 0; d < N; d++)
          for (int a = 0; a < DEPTH; a++) mem[d][a] = 8'h00;
        pp_ack = 1'b1;
        @(negedge clk);
        pp_ack = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    if (cyc > WDOG) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  task automatic fill(input int s);
    for (int d = 0; d < N; d++) begin
      rcv[d] = 0; ers_w[d] = 0; vfy_w[d] = 0; mode[d] = 0; vad[d] = 0;
      for (int a = 0; a < DEPTH; a++) begin
        case (s)
          0: need[d][a] = 1;
          1: need[d][a] = (d == 1) ? 8 : 1 + (a % 3);
          2: need[d][a] = MAXP + 1 + d;
          3: need[d][a] = (a == DEPTH - 1) ? 5 : 1;
          default: need[d][a] = 1 + ((d * 5 + a * 3 + s * 7) % ((s % 3 == 0) ? 9 : 6));
        endcase
        mem[d][a] = ((s % 2 == 1) && a == d + 2) ? 8'h5A : 8'h00;
      end
    end
    bad_gap = 0; bad_rd = 0; bad_order = 0; bad_mask = 0; bad_pp = 0; pp_seen = 0;
    go_cyc = 0; a0_cyc = 0; last_vdev = -1;
  endtask

  task automatic run_case(input int s);
    int nd, pulses, cur, w, expw;
    bit was_dirty;
    logic [N-1:0] exp_pass;
    fill(s);
    was_dirty = dirty();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10 flags cleared by start
    chk(dev_pass == '0 && dev_fail == '0, "R10", "flags after start", int'(dev_pass | dev_fail), 0);
    while (!done) @(negedge clk);
    // R2
    chk(pp_seen == int'(was_dirty), "R2", "preprogram request", pp_seen, int'(was_dirty));
    chk(bad_pp == 0, "R2", "erase while dirty", bad_pp, 0);
    chk(bad_gap == 0, "R4", "erase settle violations", bad_gap, 0);
    chk(bad_rd == 0, "R5", "verify read timing/address", bad_rd, 0);
    chk(bad_order == 0, "R7", "verify order", bad_order, 0);
    chk(bad_mask == 0, "R7", "erase to passed device", bad_mask, 0);
    chk(last_wd == 8'h00 && last_ce == '0, "R9", "final read command", int'(last_wd), 0);
    for (int d = 0; d < N; d++) begin
      nd = 1;
      for (int a = 0; a < DEPTH; a++) if (need[d][a] > nd) nd = need[d][a];
      pulses = (nd < MAXP) ? nd : MAXP;
      exp_pass[d] = (nd <= MAXP);
      cur = 0; expw = 0;
      for (int p = 1; p <= pulses; p++) begin
        if (cur < DEPTH) begin
          while (cur < DEPTH && need[d][cur] <= p) begin expw++; cur++; end
          if (cur < DEPTH) expw++;
        end
      end
      w = ers_w[d];
      chk(w == 2 * pulses, "R3", $sformatf("erase writes dev%0d", d), w, 2 * pulses);
      chk(vfy_w[d] == expw, "R6", $sformatf("verify commands dev%0d", d), vfy_w[d], expw);
    end
    chk(dev_pass == exp_pass, "R8", "pass flags", int'(dev_pass), int'(exp_pass));
    chk(dev_fail == ~exp_pass, "R8", "fail flags", int'(dev_fail), int'(~exp_pass));
    repeat (10) @(negedge clk);
    chk(dev_pass == exp_pass && dev_fail == ~exp_pass && done, "R10", "flags held while done",
        int'({dev_pass, dev_fail}), int'({exp_pass, ~exp_pass}));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(ce_n == '1 && !bus_we && !bus_re && !done && !pp_req, "R1", "idle outputs",
        int'({ce_n, bus_we, bus_re, done, pp_req}), int'({ {N{1'b1}}, 4'b0 }));
    chk(dev_pass == '0 && dev_fail == '0, "R1", "flags in reset", int'(dev_pass | dev_fail), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ce_n == '1 && !done, "R1", "idle after release", int'(ce_n), (1 << N) - 1);
    for (int s = 0; s < 12; s++) run_case(s);
    summary();
    $finish;
  end

endmodule